// File: doc/BRIEF.md
# Single-Flop Character Class Matcher Stage

This block is one state of a hardware nondeterministic automaton that scans a byte stream one character per clock. It matches a single character drawn from a configurable set: a range such as lower-case letters or digits, a union of ranges, or the complement of such a set. The character arrives already decoded as 256 one-hot lines. An activation input comes from the preceding automaton state. The block produces one registered output that feeds the next state.

The set is fixed at elaboration by a 256-bit membership mask. All selected decoder lines are merged in combinational logic ahead of one gate and one flip-flop, so the state costs one register whatever the size of the set. A second parameter picks the complemented form. In that form the inverted selected lines are combined with AND rather than OR. Only single characters and character ranges are handled. Alternation between multi-character strings needs one state per branch and is built elsewhere.

Top module: `charclass_stage`

## Requirements
- R1: A synchronous reset (`rst` high at a rising edge) forces `hit` low at that edge, whatever `prev_active` and `sym_hot` are.
- R2: With `INVERT = 0`, if `prev_active` is high and the asserted line of `sym_hot` (bit index = byte value) has its `CLASS_MASK` bit set, `hit` is high after the next rising edge.
- R3: With `INVERT = 0`, if the asserted line's mask bit is clear, `hit` is low after the next rising edge even though `prev_active` is high.
- R4: If `prev_active` is low, `hit` is low after the next rising edge for any character, in both forms.
- R5: With `INVERT = 1`, if `prev_active` is high and the asserted line's mask bit is clear, `hit` is high after the next rising edge.
- R6: With `INVERT = 1`, if the asserted line's mask bit is set, `hit` is low after the next rising edge.
- R7: One character is consumed per cycle. `hit` after each edge depends only on the inputs sampled at that edge, with no hold-over from earlier cycles.
- R8: Range endpoints are members and their outside neighbours are not. For a mask covering 0x61..0x7A and 0x30..0x39, bytes 0x61, 0x7A, 0x30 and 0x39 match in the direct form, and 0x60, 0x7B, 0x2F and 0x3A do not.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; one character per rising edge |
| rst | input | 1 | Synchronous active-high reset of the state flop |
| sym_hot | input | SYMBOLS | One-hot decoded current character, bit n for byte value n |
| prev_active | input | 1 | Activation from the preceding automaton state |
| hit | output | 1 | Registered state output toward the next state |

## Verification
Two situations are hard to reach from the ports. The first is a member character that arrives while the activation is low. The second is a reset that lands while the output is already high and the inputs would keep it high. The stimulus table drives member and non-member characters with the activation both high and low, and places range endpoints next to non-members in consecutive cycles. A directed sequence first raises `hit`, then holds a matching input while reset is applied, so that the only reason for the low output is the reset.

// File: rtl/charclass_stage.sv
module charclass_stage #(
  parameter int SYMBOLS = 256,
  parameter logic [SYMBOLS-1:0] CLASS_MASK = {{(SYMBOLS-58){1'b0}}, 10'h3FF, 48'h0},
  parameter bit INVERT = 1'b0
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [SYMBOLS-1:0] sym_hot,
  input  logic               prev_active,
  output logic               hit
);

  logic [SYMBOLS-1:0] picked;
  logic               take;

  assign picked = sym_hot & CLASS_MASK;

  generate
    if (INVERT) begin : g_neg
      assign take = &(~picked);
    end else begin : g_pos
      assign take = |picked;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) hit <= 1'b0;
    else     hit <= prev_active & take;
  end

  assert_idle_clears_R4: assert property (@(posedge clk) disable iff (rst)
    !prev_active |=> !hit);

  assert_hit_needs_enable_R4: assert property (@(posedge clk) disable iff (rst)
    hit |-> $past(prev_active));

  generate
    if (INVERT) begin : g_chk_neg
      assert_outside_matches_R5: assert property (@(posedge clk) disable iff (rst)
        (prev_active && (sym_hot & CLASS_MASK) == '0) |=> hit);
      assert_member_rejected_R6: assert property (@(posedge clk) disable iff (rst)
        ((sym_hot & CLASS_MASK) != '0) |=> !hit);
    end else begin : g_chk_pos
      assert_member_matches_R2: assert property (@(posedge clk) disable iff (rst)
        (prev_active && (sym_hot & CLASS_MASK) != '0) |=> hit);
      assert_outside_rejected_R3: assert property (@(posedge clk) disable iff (rst)
        ((sym_hot & CLASS_MASK) == '0) |=> !hit);
    end
  endgenerate

endmodule

// File: tb/charclass_stage_test.sv
`timescale 1ns/1ps
module charclass_stage_test;

  // Class: 0x61..0x7A and 0x30..0x39
  function automatic logic [255:0] build_mask();
    logic [255:0] m = '0;
    for (int i = 8'h61; i <= 8'h7A; i++) m[i] = 1'b1;
    for (int i = 8'h30; i <= 8'h39; i++) m[i] = 1'b1;
    return m;
  endfunction
  localparam logic [255:0] MASK = build_mask();

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [255:0] sym_hot = 256'b1 << 8'h61;
  logic en = 1'b1;
  logic hit_pos, hit_neg;
  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  charclass_stage #(.SYMBOLS(256), .CLASS_MASK(MASK), .INVERT(1'b0)) uut (
    .clk(clk), .rst(rst), .sym_hot(sym_hot), .prev_active(en), .hit(hit_pos));

  charclass_stage #(.SYMBOLS(256), .CLASS_MASK(MASK), .INVERT(1'b1)) uut_neg (
    .clk(clk), .rst(rst), .sym_hot(sym_hot), .prev_active(en), .hit(hit_neg));

  // {enable, byte, expected direct, expected complemented}
  localparam logic [10:0] VEC [0:15] = '{
    {1'b1, 8'h61, 1'b1, 1'b0},   // R8 low end
    {1'b1, 8'h7A, 1'b1, 1'b0},   // R8 high end
    {1'b1, 8'h60, 1'b0, 1'b1},   // R8 below
    {1'b1, 8'h7B, 1'b0, 1'b1},   // R8 above
    {1'b1, 8'h30, 1'b1, 1'b0},
    {1'b1, 8'h39, 1'b1, 1'b0},
    {1'b1, 8'h2F, 1'b0, 1'b1},
    {1'b1, 8'h3A, 1'b0, 1'b1},
    {1'b0, 8'h6D, 1'b0, 1'b0},
    {1'b0, 8'h23, 1'b0, 1'b0},
    {1'b1, 8'h6D, 1'b1, 1'b0},
    {1'b1, 8'h23, 1'b0, 1'b1},
    {1'b1, 8'h00, 1'b0, 1'b1},
    {1'b1, 8'hFF, 1'b0, 1'b1},
    {1'b1, 8'h71, 1'b1, 1'b0},
    {1'b0, 8'h71, 1'b0, 1'b0}
  };

  task automatic check(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%b expected=%b", req, act, exp);
    end
  endtask

  task automatic step(input logic e, input logic [7:0] ch);
    en = e;
    sym_hot = 256'b1 << ch;
    @(negedge clk);
  endtask

  initial begin
    @(negedge clk);
    @(negedge clk);
    check("R1", hit_pos, 1'b0);
    check("R1", hit_neg, 1'b0);
    rst = 1'b0;

    for (int k = 0; k < 16; k++) begin
      step(VEC[k][10], VEC[k][9:2]);
      check(!VEC[k][10] ? "R4" : (VEC[k][1] ? "R2" : "R3"), hit_pos, VEC[k][1]);
      check(!VEC[k][10] ? "R4" : (VEC[k][0] ? "R5" : "R6"), hit_neg, VEC[k][0]);
    end

    // R8: boundaries in consecutive cycles
    step(1'b1, 8'h39); check("R8", hit_pos, 1'b1);
    step(1'b1, 8'h3A); check("R8", hit_pos, 1'b0);
    step(1'b1, 8'h60); check("R8", hit_neg, 1'b1);
    step(1'b1, 8'h61); check("R8", hit_neg, 1'b0);

    // R7: alternate every cycle, no hold-over
    for (int k = 0; k < 6; k++) begin
      step(1'b1, (k % 2 == 0) ? 8'h62 : 8'h21);
      check("R7", hit_pos, (k % 2 == 0));
      check("R7", hit_neg, (k % 2 != 0));
    end

    // R4: enable drops right after a match
    step(1'b1, 8'h35); check("R2", hit_pos, 1'b1);
    step(1'b0, 8'h35); check("R4", hit_pos, 1'b0);

    // R1: reset while output high and inputs would keep it high
    step(1'b1, 8'h63); check("R2", hit_pos, 1'b1);
    rst = 1'b1;
    @(negedge clk);
    check("R1", hit_pos, 1'b0);
    check("R1", hit_neg, 1'b0);
    rst = 1'b0;
    @(negedge clk);
    check("R2", hit_pos, 1'b1);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule